// File: doc/BRIEF.md
# Core System Tick Timer

A down-counting tick timer that gives a processor core a steady periodic interrupt. Software programs a reload value, picks the count source and enables the counter. The count source is either every cycle of the core clock or a single-cycle reference tick-enable input. Each time the counter passes from 1 to 0 it reloads in the same step, sets a sticky count flag and, when the tick interrupt is enabled, raises the interrupt level.

A read-only calibration word is fixed at elaboration from two parameters: the reference tick frequency and whether a reference tick exists at all. Software uses the word to find the reload value for a 10 ms period. When no reference tick exists, the core-clock source is forced on and the calibration word reports only that fact.

All registers sit on a simple synchronous port. Writes take effect at the clock edge. Read data is combinational from the current state while the read strobe is high, and read side effects act at the same edge.

Top module: `systick_timer`

## Requirements
- R1: After synchronous reset the control word, reload value and current value all read 0 and `irq` is low.
- R2: Control word at offset 0x0: bit 0 is run enable, bit 1 is tick-interrupt enable, bit 2 is the source select (1 = core clock, 0 = reference tick), and bit 16 is the count flag. Bit 16 is read-only, and all other bits read 0.
- R3: With source select 1 the counter takes a step on every clock cycle while enabled. With source select 0 it steps only in cycles where `ref_tick` is high.
- R4: On a step, a current value above 1 decrements by one, and a current value of 0 or 1 loads the reload value (offset 0x4, bits 23:0). Once loaded, a reload value R yields one 1-to-0 passage every R steps.
- R5: A step taken at current value 1 sets the count flag. `irq` is high exactly when the count flag and tick-interrupt enable are both 1.
- R6: A read of the control word returns the flag as it was before the read and clears it at that edge, unless a 1-to-0 step sets it in the same cycle.
- R7: Any write to the current value (offset 0x8) clears the counter and the count flag. This takes priority over a step in the same cycle.
- R8: With reload value 0 and current value 0, the counter stays at 0 and the flag is not set.
- R9: With run enable 0 the current value holds.
- R10: Without a reference tick (HAS_REF = 0), bit 2 reads 1 after reset and after any write that clears it, and `ref_tick` has no effect.
- R11: Calibration word at offset 0xC. With a reference tick, bits 23:0 = REF_HZ/100 - 1, and bit 30 (skew) = 1 when REF_HZ is not a multiple of 100. Without a reference tick the word is 0x8000_0000.
- R12: Offsets other than 0x0, 0x4, 0x8 and 0xC read 0 and ignore writes. Reload bits 31:24 are dropped on write and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick enable, one cycle per reference tick |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when `bus_rd` is low |
| irq | output | 1 | Interrupt level |

## Verification
The assertions check the following on every cycle: the current value holds while the counter is stopped, a 1-to-0 step reloads and sets the flag, a zero reload keeps the counter idle, a current-value write clears counter and flag, a control read clears the flag, and the forced source bit when no reference tick exists. The bench's scenarios are needed for the rest. These are the exact counting periods under a sparse reference tick, the read-before-clear value of the flag, the calibration words for exact, skewed and missing reference frequencies, and the handling of unmapped offsets and truncated reload bits. A behavioural model tracks all of this cycle by cycle.

// File: rtl/systick_pkg.sv
`timescale 1ns/1ps
package systick_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    localparam logic [BUS_AW-1:0] OFF_CTRL   = 8'h00;
    localparam logic [BUS_AW-1:0] OFF_RELOAD = 8'h04;
    localparam logic [BUS_AW-1:0] OFF_CURR   = 8'h08;
    localparam logic [BUS_AW-1:0] OFF_CALIB  = 8'h0C;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_IRQ_BIT  = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 16;

    localparam int CAL_FIELD_W  = 24;
    localparam int CAL_SKEW_BIT = 30;
    localparam int CAL_NREF_BIT = 31;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_RELOAD,
        SEL_CURR,
        SEL_CALIB,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic core_src;
        logic tick_irq;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_reload;
        logic wr_curr;
        logic rd_ctrl;
    } bus_evt_t;

    function automatic reg_sel_e decode_addr(input logic [BUS_AW-1:0] a);
        case (a)
            OFF_CTRL:   return SEL_CTRL;
            OFF_RELOAD: return SEL_RELOAD;
            OFF_CURR:   return SEL_CURR;
            OFF_CALIB:  return SEL_CALIB;
            default:    return SEL_NONE;
        endcase
    endfunction

    // Word that tells software how many reference ticks make 10 ms.
    function automatic logic [BUS_DW-1:0] calib_word(input longint unsigned ref_hz,
                                                     input bit has_ref);
        logic [BUS_DW-1:0] w;
        longint unsigned   per10;
        w = '0;
        if (!has_ref) begin
            w[CAL_NREF_BIT] = 1'b1;
        end else begin
            per10 = ref_hz / 100;
            w[CAL_FIELD_W-1:0] = CAL_FIELD_W'(per10 - 1);
            w[CAL_SKEW_BIT]    = (ref_hz % 100) != 0;
        end
        return w;
    endfunction

    function automatic logic [BUS_DW-1:0] pack_ctrl(input ctrl_t c, input logic flag);
        logic [BUS_DW-1:0] w;
        w = '0;
        w[CTRL_RUN_BIT]  = c.run;
        w[CTRL_IRQ_BIT]  = c.tick_irq;
        w[CTRL_SRC_BIT]  = c.core_src;
        w[CTRL_FLAG_BIT] = flag;
        return w;
    endfunction

endpackage

// File: rtl/st_tick_src.sv
`timescale 1ns/1ps
module st_tick_src #(
    parameter bit HAS_REF = 1'b1
) (
    input  logic core_src,
    input  logic ref_tick,
    output logic step_req
);
    generate
        if (HAS_REF) begin : g_ref
            assign step_req = core_src ? 1'b1 : ref_tick;
        end else begin : g_noref
            logic unused_tick;
            assign unused_tick = ref_tick ^ core_src;
            assign step_req    = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/st_down_counter.sv
`timescale 1ns/1ps
module st_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             step_req,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cur,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             step;
    logic             at_reload;
    logic [CNT_W-1:0] cur_nxt;

    assign step      = run && step_req && !clr;
    assign at_reload = (cur == '0) || (cur == ONE);
    assign wrap      = step && (cur == ONE);

    always_comb begin
        cur_nxt = cur;
        if (clr)
            cur_nxt = '0;
        else if (step)
            cur_nxt = at_reload ? reload_val : cur - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= cur_nxt;
    end

    assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(cur));
    assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (rst)
        (run && step_req && !clr && cur == ONE) |=> (cur == $past(reload_val)));
    assert_zero_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (cur == '0 && reload_val == '0 && !clr) |=> (cur == '0));
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cur == '0));
endmodule

// File: rtl/st_ctrl_reg.sv
`timescale 1ns/1ps
module st_ctrl_reg
    import systick_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter bit HAS_REF = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BUS_DW-1:0] wdata,
    input  logic              wrap,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              flag
);
    logic  unused_wbits;
    ctrl_t ctrl_nxt;

    assign unused_wbits = ^{wdata[BUS_DW-1:CNT_W], wdata[CNT_W-1:CTRL_SRC_BIT+1]};

    always_comb begin
        ctrl_nxt          = ctrl;
        ctrl_nxt.run      = wdata[CTRL_RUN_BIT];
        ctrl_nxt.tick_irq = wdata[CTRL_IRQ_BIT];
        ctrl_nxt.core_src = HAS_REF ? wdata[CTRL_SRC_BIT] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl          <= '0;
            ctrl.core_src <= !HAS_REF;
            reload        <= '0;
        end else begin
            if (evt.wr_ctrl)   ctrl   <= ctrl_nxt;
            if (evt.wr_reload) reload <= wdata[CNT_W-1:0];
        end
    end

    // Priority: current-value write clears, then a wrap sets, then a read clears.
    always_ff @(posedge clk) begin
        if (rst)               flag <= 1'b0;
        else if (evt.wr_curr)  flag <= 1'b0;
        else if (wrap)         flag <= 1'b1;
        else if (evt.rd_ctrl)  flag <= 1'b0;
    end

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        (wrap && !evt.wr_curr) |=> flag);
    assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.rd_ctrl && !wrap) |=> !flag);
    assert_curr_wr_clear_R7: assert property (@(posedge clk) disable iff (rst)
        evt.wr_curr |=> !flag);
endmodule

// File: rtl/st_bus_if.sv
`timescale 1ns/1ps
module st_bus_if
    import systick_pkg::*;
#(
    parameter int                CNT_W = 24,
    parameter logic [BUS_DW-1:0] CALIB = '0
) (
    input  logic [BUS_AW-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  ctrl_t             ctrl,
    input  logic              flag,
    input  logic [CNT_W-1:0]  reload,
    input  logic [CNT_W-1:0]  cur,
    output bus_evt_t          evt,
    output logic [BUS_DW-1:0] rdata
);
    reg_sel_e sel;

    assign sel         = decode_addr(addr);
    assign evt.wr_ctrl   = wr && (sel == SEL_CTRL);
    assign evt.wr_reload = wr && (sel == SEL_RELOAD);
    assign evt.wr_curr   = wr && (sel == SEL_CURR);
    assign evt.rd_ctrl   = rd && (sel == SEL_CTRL);

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (sel)
                SEL_CTRL:   rdata = pack_ctrl(ctrl, flag);
                SEL_RELOAD: rdata = BUS_DW'(reload);
                SEL_CURR:   rdata = BUS_DW'(cur);
                SEL_CALIB:  rdata = CALIB;
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/systick_timer.sv
`timescale 1ns/1ps
module systick_timer
    import systick_pkg::*;
#(
    parameter int              CNT_W   = 24,
    parameter longint unsigned REF_HZ  = 1000000,
    parameter bit              HAS_REF = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [BUS_DW-1:0] CALIB = calib_word(REF_HZ, HAS_REF);

    bus_evt_t         evt;
    ctrl_t            ctrl;
    logic             flag;
    logic             wrap;
    logic             step_req;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cur;

    st_bus_if #(.CNT_W(CNT_W), .CALIB(CALIB)) u_bus (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .ctrl(ctrl), .flag(flag), .reload(reload), .cur(cur),
        .evt(evt), .rdata(bus_rdata)
    );

    st_ctrl_reg #(.CNT_W(CNT_W), .HAS_REF(HAS_REF)) u_regs (
        .clk(clk), .rst(rst), .evt(evt), .wdata(bus_wdata), .wrap(wrap),
        .ctrl(ctrl), .reload(reload), .flag(flag)
    );

    st_tick_src #(.HAS_REF(HAS_REF)) u_src (
        .core_src(ctrl.core_src), .ref_tick(ref_tick), .step_req(step_req)
    );

    st_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctrl.run), .step_req(step_req),
        .clr(evt.wr_curr), .reload_val(reload), .cur(cur), .wrap(wrap)
    );

    assign irq = flag && ctrl.tick_irq;

    assert_src_forced_R10: assert property (@(posedge clk) disable iff (rst)
        (!HAS_REF && bus_rd && bus_addr == OFF_CTRL) |-> bus_rdata[CTRL_SRC_BIT]);
    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(wrap) || $past(evt.wr_ctrl)));
endmodule

// File: tb/systick_timer_tb_top.sv
`timescale 1ns/1ps
module systick_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_main, rd_noref, rd_skew;
    logic        irq_main, irq_noref, irq_skew;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit ref_on = 1'b0;
    int ref_ph = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    systick_timer dut_i (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rd_main), .irq(irq_main));
    systick_timer #(.HAS_REF(1'b0)) dut_noref (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rd_noref), .irq(irq_noref));
    systick_timer #(.REF_HZ(32768)) dut_skew (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(rd_skew), .irq(irq_skew));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference tick: one pulse every third cycle while enabled.
    always @(negedge clk) begin
        ref_ph   <= (ref_ph == 2) ? 0 : ref_ph + 1;
        ref_tick <= ref_on && (ref_ph == 0);
    end

    // Behavioural model of the main instance.
    bit          m_run, m_irqen, m_src, m_flag;
    int unsigned m_cur, m_reload;
    always @(posedge clk) begin
        bit          stepping, setf;
        int unsigned nc;
        if (rst) begin
            m_run = 0; m_irqen = 0; m_src = 0; m_flag = 0; m_cur = 0; m_reload = 0;
        end else begin
            stepping = m_run && (m_src || ref_tick);
            setf = 0;
            nc = m_cur;
            if (stepping) begin
                if (m_cur == 1) begin nc = m_reload; setf = 1; end
                else if (m_cur == 0) nc = m_reload;
                else nc = m_cur - 1;
            end
            if (bus_rd && bus_addr == 8'h00) m_flag = 0;
            if (setf) m_flag = 1;
            if (bus_wr && bus_addr == 8'h08) begin nc = 0; m_flag = 0; end
            if (bus_wr && bus_addr == 8'h00) begin
                m_run = bus_wdata[0]; m_irqen = bus_wdata[1]; m_src = bus_wdata[2];
            end
            if (bus_wr && bus_addr == 8'h04) m_reload = bus_wdata & 32'h00FF_FFFF;
            m_cur = nc;
        end
    end

    function automatic logic [31:0] model_rdata();
        if (!bus_rd) return 32'h0;
        case (bus_addr)
            8'h00: return {15'h0, m_flag, 13'h0, m_src, m_irqen, m_run};
            8'h04: return m_reload;
            8'h08: return m_cur;
            8'h0C: return 32'd9999;
            default: return 32'h0;
        endcase
    endfunction

    // Per-cycle comparison (R3 R4 R5 R6 R7 R8 R9 R12 behaviour over time).
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check("R4/R5 per-cycle irq", {31'h0, irq_main}, {31'h0, m_flag & m_irqen});
            check("R3/R6/R7 per-cycle rdata", rd_main, model_rdata());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected <= 50000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] vm,
                         output logic [31:0] vn, output logic [31:0] vs);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        vm = rd_main; vn = rd_noref; vs = rd_skew;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 200 && !irq_main; i++) @(negedge clk);
        #1;
    endtask

    initial begin
        logic [31:0] a, b, c, v1, v2;
        idle(3);
        rst = 1'b0;

        // R1 reset state; R10 source bit forced after reset
        check("R1 irq after reset", {31'h0, irq_main}, 32'h0);
        bread(8'h00, a, b, c);
        check("R1 control after reset", a, 32'h0);
        check("R10 source reads 1 after reset", b, 32'h4);
        bread(8'h04, a, b, c);
        check("R1 reload after reset", a, 32'h0);
        bread(8'h08, a, b, c);
        check("R1 current after reset", a, 32'h0);

        // R11 calibration words
        bread(8'h0C, a, b, c);
        check("R11 calib exact", a, 32'd1000000 / 100 - 1);
        check("R11 calib no reference", b, 32'h8000_0000);
        check("R11 calib skew", c, 32'h4000_0000 | (32'd32768 / 100 - 1));

        // R12 unmapped offsets and reload truncation
        bwrite(8'h10, 32'hFFFF_FFFF);
        bread(8'h10, a, b, c);
        check("R12 unmapped read zero", a, 32'h0);
        bwrite(8'h06, 32'h0000_0007);
        bread(8'h04, a, b, c);
        check("R12 misaligned write ignored", a, 32'h0);
        bwrite(8'h04, 32'hFFFF_FFFF);
        bread(8'h04, a, b, c);
        check("R12 reload upper bits dropped", a, 32'h00FF_FFFF);

        // R8 zero reload idles
        bwrite(8'h04, 32'h0);
        bwrite(8'h00, 32'h5);
        idle(10);
        bread(8'h08, a, b, c);
        check("R8 current stays zero", a, 32'h0);
        bread(8'h00, a, b, c);
        check("R8 no flag with zero reload", {31'h0, a[16]}, 32'h0);

        // R4/R5 counting to wrap on the core clock, R6 read-clear
        bwrite(8'h00, 32'h0);
        bwrite(8'h04, 32'd20);
        bwrite(8'h08, 32'h0);
        bwrite(8'h00, 32'h7);
        wait_irq();
        check("R5 irq raised on wrap", {31'h0, irq_main}, 32'h1);
        bwrite(8'h00, 32'h2);
        bread(8'h00, a, b, c);
        check("R6 read returns set flag", a, 32'h0001_0002);
        bread(8'h00, a, b, c);
        check("R6 flag cleared by read", a, 32'h0000_0002);
        check("R5 irq low after clear", {31'h0, irq_main}, 32'h0);

        // R7 current-value write clears counter and flag
        bwrite(8'h00, 32'h7);
        wait_irq();
        bwrite(8'h00, 32'h2);
        bwrite(8'h08, 32'd5);
        bread(8'h08, a, b, c);
        check("R7 current cleared", a, 32'h0);
        bread(8'h00, a, b, c);
        check("R7 flag cleared", {31'h0, a[16]}, 32'h0);

        // R9 stopped counter holds
        bwrite(8'h04, 32'd200);
        bwrite(8'h00, 32'h5);
        idle(30);
        bwrite(8'h00, 32'h4);
        bread(8'h08, v1, b, c);
        idle(10);
        bread(8'h08, v2, b, c);
        check("R9 value holds while stopped", v2, v1);
        check("R9 value nonzero", {31'h0, v1 != 0}, 32'h1);

        // R3 reference source; R10 ref ignored without a reference
        bwrite(8'h08, 32'h0);
        bwrite(8'h04, 32'd10);
        bwrite(8'h00, 32'h1);
        idle(30);
        bread(8'h08, a, b, c);
        check("R3 no steps without reference ticks", a, 32'h0);
        bread(8'h00, a, b, c);
        check("R10 source forced after clearing write", {31'h0, b[2]}, 32'h1);
        check("R10 counts on core clock", {31'h0, b[16]}, 32'h1);
        ref_on = 1'b1;
        idle(100);
        bread(8'h00, a, b, c);
        check("R3 reference ticks reach wrap", {31'h0, a[16]}, 32'h1);
        check("R2 control fields", a & 32'hFFFE_FFFF, 32'h1);

        // Mixed reload change while running on the core clock
        bwrite(8'h00, 32'h7);
        bwrite(8'h04, 32'd3);
        idle(40);
        ref_on = 1'b0;
        bwrite(8'h00, 32'h0);
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule